// File: doc/BRIEF.md
# DMA Instruction Stream Parser

This block sits in front of a DMA engine and reads instructions that arrive as a stream of 64-bit words. Each word comes with a valid/ready handshake. An instruction starts with a header word. Two pointer areas follow: a source-side area and then a destination-side area. The header gives the transfer direction and how many pointers each area holds. From these the parser works out how many words each area occupies. An area of local memory pointers takes one word per pointer. An area of PCIe components also carries one packed length word in front of each group of up to four PCIe addresses.

Every accepted word is labelled on a kind output one cycle after it is accepted. While the words pass, the parser checks the header's per-direction must-be-zero rules, the pointer sizes, the overall word budget and the byte balance between the two areas. A rule violation does not stop parsing: the rest of the instruction is still consumed, so the next header is found at the right place. One cycle after the last word of an instruction, a single-cycle descriptor pulse reports the decoded fields, the source-area byte total and one error flag.

Top module: `dmap_instr_parse`

## Requirements
- R1: The header layout, from bit 63 down, is: reserved[63:60], source port[59:58], destination port[57:56], direction[55:54], completion-is-work-entry[53], five option flags[52:48] (counter select, counter add, force interrupt, ignore invert, free local), destination count[47:44], source count[43:40] and completion pointer[39:0]. The descriptor reports the direction and the pointer of the instruction. Direction codes are 0 local-to-PCIe, 1 PCIe-to-local, 2 local-to-local and 3 PCIe-to-PCIe.
- R2: An area of N local pointers is N words long. An area of N PCIe components is N + floor((N+3)/4) words long. The source area holds PCIe components only for direction 3. The destination area holds local pointers only for direction 2. The descriptor reports both area lengths in words.
- R3: Each accepted word raises k_valid for one cycle, one cycle after acceptance, with k_kind set to 0 for a header, 1 for a local pointer, 2 for a PCIe address and 3 for a PCIe length word. A PCIe area is made of groups, each a length word followed by up to four addresses.
- R4: d_valid pulses for one cycle exactly one cycle after the final word of an instruction is accepted. For an instruction with both counts zero, that final word is the header itself. Back-to-back instructions are accepted without idle cycles.
- R5: If the two area lengths together exceed 31 words, the error flag is set.
- R6: A local pointer whose 13-bit size field (bits 52:40) is zero sets the error flag.
- R7: A PCIe length word holds four 16-bit lengths: slot 0 in bits 63:48 down to slot 3 in bits 15:0. Slots past the last address of the area are ignored. The error flag is set unless the byte totals of the two areas are equal. d_bytes reports the source-area total.
- R8: For directions 1 and 2, all five option flags must be zero. For direction 3, the ignore-invert and free-local flags must be zero. Any other value sets the error flag.
- R9: The error flag is set if the source port is nonzero for any direction other than 3, or if the destination port is nonzero for direction 2.
- R10: A nonzero reserved field sets the error flag.
- R11: If the completion-is-work-entry bit is 1 and pointer bits 2:0 are nonzero, the error flag is set. With those bits zero, the instruction is legal.
- R12: An instruction with errors is still consumed to its computed end. Its error does not carry into the next instruction.
- R13: During reset, in_ready is low. After reset, k_valid and d_valid are low and the first accepted word is taken as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Parser can accept a word |
| in_data | input | 64 | Instruction word |
| k_valid | output | 1 | Word label valid |
| k_kind | output | 2 | Label of the word accepted one cycle earlier |
| d_valid | output | 1 | Descriptor pulse at the end of an instruction |
| d_type | output | 2 | Transfer direction |
| d_first_words | output | 5 | Source-area length in words |
| d_last_words | output | 5 | Destination-area length in words |
| d_bytes | output | 20 | Source-area byte total |
| d_ptr | output | 40 | Completion pointer |
| d_error | output | 1 | Instruction broke at least one rule |

## Verification
The hardest situation to reach is a PCIe area whose last group holds fewer than four addresses. To pass, the unused length slots must be left out of the byte balance. The error must also be reported while the stream keeps its alignment over words that no longer match the budget. The stimulus fills every unused slot with random junk and pads the destination area so its total matches the source exactly. A balanced instruction therefore passes only if the junk is ignored. Directed cases add a 15+15 external instruction that exceeds the word budget, followed at once by a clean instruction. Random headers with occasional flipped high bits reach every per-direction rule.

// File: rtl/dmap_pkg.sv
package dmap_pkg;
   localparam int unsigned WORD_W = 64;
   localparam int unsigned CNT_W  = 4;
   localparam int unsigned LEN_W  = 16;
   localparam int unsigned SIZE_W = 13;
   localparam int unsigned SIZE_LSB = 40;
   localparam int unsigned PTR_W  = 40;

   typedef enum logic [1:0] {
      XF_TO_PCIE   = 2'd0,
      XF_FROM_PCIE = 2'd1,
      XF_LOCAL     = 2'd2,
      XF_REMOTE    = 2'd3
   } xfer_e;

   typedef enum logic [1:0] {
      WK_HDR   = 2'd0,
      WK_LOCAL = 2'd1,
      WK_PADDR = 2'd2,
      WK_PLEN  = 2'd3
   } wkind_e;

   typedef struct packed {
      logic [3:0]       rsvd;
      logic [1:0]       src_port;
      logic [1:0]       dst_port;
      xfer_e            xfer;
      logic             wq_entry;
      logic             cnt_sel;
      logic             cnt_add;
      logic             force_int;
      logic             ign_inv;
      logic             free_loc;
      logic [CNT_W-1:0] n_dst;
      logic [CNT_W-1:0] n_src;
      logic [PTR_W-1:0] cptr;
   } hdr_t;
endpackage

// File: rtl/dmap_hdr_check.sv
module dmap_hdr_check
   import dmap_pkg::*;
#(
   parameter int unsigned GROUP     = 4,
   parameter int unsigned MAX_WORDS = 31,
   parameter int unsigned AW_W      = 5
) (
   input  logic [WORD_W-1:0] word,
   output logic [1:0]        xfer,
   output logic [CNT_W-1:0]  n_src,
   output logic [CNT_W-1:0]  n_dst,
   output logic [PTR_W-1:0]  cptr,
   output logic              src_pcie,
   output logic              dst_pcie,
   output logic [AW_W-1:0]   src_words,
   output logic [AW_W-1:0]   dst_words,
   output logic              bad
);
   hdr_t h;
   assign h = hdr_t'(word);

   function automatic logic [AW_W-1:0] area_len(input logic [CNT_W-1:0] n, input logic pcie);
      int unsigned t;
      t = int'(n);
      if (pcie) t = t + (t + GROUP - 1) / GROUP;
      return AW_W'(t);
   endfunction

   logic flags_any, flags_free;
   logic rule_rsvd, rule_flags, rule_ports, rule_align, rule_budget;

   always_comb begin
      xfer      = h.xfer;
      n_src     = h.n_src;
      n_dst     = h.n_dst;
      cptr      = h.cptr;
      src_pcie  = (h.xfer == XF_REMOTE);
      dst_pcie  = (h.xfer != XF_LOCAL);
      src_words = area_len(h.n_src, src_pcie);
      dst_words = area_len(h.n_dst, dst_pcie);

      flags_free = h.ign_inv | h.free_loc;
      flags_any  = h.cnt_sel | h.cnt_add | h.force_int | flags_free;

      rule_rsvd  = (h.rsvd != '0);
      rule_flags = ((h.xfer == XF_FROM_PCIE || h.xfer == XF_LOCAL) && flags_any) ||
                   ((h.xfer == XF_REMOTE) && flags_free);
      rule_ports = ((h.xfer != XF_REMOTE) && (h.src_port != '0)) ||
                   ((h.xfer == XF_LOCAL) && (h.dst_port != '0));
      rule_align = h.wq_entry && (h.cptr[2:0] != 3'b000);
      rule_budget = (int'(src_words) + int'(dst_words)) > int'(MAX_WORDS);

      bad = rule_rsvd | rule_flags | rule_ports | rule_align | rule_budget;
   end
endmodule

// File: rtl/dmap_area_walk.sv
module dmap_area_walk
   import dmap_pkg::*;
#(
   parameter int unsigned GROUP = 4,
   parameter int unsigned SUM_W = 20,
   localparam int unsigned GRP_W = $clog2(GROUP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_cnt,
   input  logic              load_pcie,
   input  logic              step,
   input  logic [WORD_W-1:0] word,
   output logic [1:0]        kind,
   output logic              last_word,
   output logic              empty,
   output logic              size_bad,
   output logic [SUM_W-1:0]  add
);
   logic [CNT_W-1:0] rem_q;
   logic [GRP_W-1:0] grp_q;
   logic             pcie_q;
   logic [GRP_W-1:0] grp_fill;

   always_comb begin
      if (!pcie_q)            kind = WK_LOCAL;
      else if (grp_q == '0)   kind = WK_PLEN;
      else                    kind = WK_PADDR;
      last_word = pcie_q ? ((grp_q != '0) && (rem_q == CNT_W'(1))) : (rem_q == CNT_W'(1));
      empty     = (rem_q == '0);
      size_bad  = !pcie_q && (word[SIZE_LSB +: SIZE_W] == '0);
      grp_fill  = (int'(rem_q) > int'(GROUP)) ? GRP_W'(GROUP) : GRP_W'(rem_q);
      add = '0;
      if (!pcie_q) begin
         add = SUM_W'(word[SIZE_LSB +: SIZE_W]);
      end else if (grp_q == '0) begin
         for (int g = 0; g < int'(GROUP); g++) begin
            if (g < int'(rem_q))
               add = add + SUM_W'(word[WORD_W-1-g*LEN_W -: LEN_W]);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         grp_q  <= '0;
         pcie_q <= 1'b0;
      end else if (load) begin
         rem_q  <= load_cnt;
         grp_q  <= '0;
         pcie_q <= load_pcie;
      end else if (step) begin
         if (!pcie_q) begin
            rem_q <= rem_q - CNT_W'(1);
         end else if (grp_q == '0) begin
            grp_q <= grp_fill;
         end else begin
            grp_q <= grp_q - GRP_W'(1);
            rem_q <= rem_q - CNT_W'(1);
         end
      end
   end

   assert_group_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(grp_q) <= int'(GROUP));
   assert_len_then_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && pcie_q && grp_q == '0) |=> (kind == WK_PADDR));
endmodule

// File: rtl/dmap_byte_sum.sv
module dmap_byte_sum #(
   parameter int unsigned SUM_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             en,
   input  logic [SUM_W-1:0] add,
   output logic [SUM_W-1:0] sum_next
);
   logic [SUM_W-1:0] sum_q;

   assign sum_next = clear ? '0 : (en ? sum_q + add : sum_q);

   always_ff @(posedge clk) begin
      if (!rst_n) sum_q <= '0;
      else        sum_q <= sum_next;
   end

   assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !en) |=> (sum_q == '0));
endmodule

// File: rtl/dmap_instr_parse.sv
module dmap_instr_parse
   import dmap_pkg::*;
#(
   parameter int unsigned SUM_W     = 20,
   parameter int unsigned GROUP     = 4,
   parameter int unsigned MAX_WORDS = 31,
   localparam int unsigned MAXN = (1 << CNT_W) - 1,
   localparam int unsigned MAXA = MAXN + (MAXN + GROUP - 1) / GROUP,
   localparam int unsigned AW_W = $clog2(MAXA + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   output logic              k_valid,
   output logic [1:0]        k_kind,
   output logic              d_valid,
   output logic [1:0]        d_type,
   output logic [AW_W-1:0]   d_first_words,
   output logic [AW_W-1:0]   d_last_words,
   output logic [SUM_W-1:0]  d_bytes,
   output logic [PTR_W-1:0]  d_ptr,
   output logic              d_error
);
   generate
      if (SUM_W < LEN_W + CNT_W) begin : g_sum_too_narrow
         $error("SUM_W cannot hold the largest area total");
      end
      if (GROUP * LEN_W > WORD_W) begin : g_group_too_wide
         $error("GROUP lengths do not fit in one word");
      end
   endgenerate

   typedef enum logic [1:0] {ST_HDR, ST_SRC, ST_DST} st_e;
   st_e st_q;

   logic              ready_q, fire, load, done, word_bad, err_q, err_now;
   logic [1:0]        h_xfer;
   logic [CNT_W-1:0]  h_nsrc, h_ndst;
   logic [PTR_W-1:0]  h_ptr;
   logic              h_src_pcie, h_dst_pcie, h_bad;
   logic [AW_W-1:0]   h_src_words, h_dst_words;
   logic [1:0]        cur_kind;

   logic [1:0]        typ_q;
   logic [PTR_W-1:0]  ptr_q;
   logic [AW_W-1:0]   sw_q, dw_q;

   logic [CNT_W-1:0]  a_cnt   [2];
   logic              a_pcie  [2];
   logic              a_step  [2];
   logic [1:0]        a_kind  [2];
   logic              a_last  [2];
   logic              a_empty [2];
   logic              a_zero  [2];
   logic [SUM_W-1:0]  a_add   [2];
   logic [SUM_W-1:0]  a_sum   [2];

   assign in_ready = ready_q;
   assign fire     = in_valid && ready_q;
   assign load     = fire && (st_q == ST_HDR);

   dmap_hdr_check #(.GROUP(GROUP), .MAX_WORDS(MAX_WORDS), .AW_W(AW_W)) u_hdr (
      .word(in_data), .xfer(h_xfer), .n_src(h_nsrc), .n_dst(h_ndst), .cptr(h_ptr),
      .src_pcie(h_src_pcie), .dst_pcie(h_dst_pcie),
      .src_words(h_src_words), .dst_words(h_dst_words), .bad(h_bad)
   );

   assign a_cnt[0]  = h_nsrc;
   assign a_cnt[1]  = h_ndst;
   assign a_pcie[0] = h_src_pcie;
   assign a_pcie[1] = h_dst_pcie;
   assign a_step[0] = fire && (st_q == ST_SRC);
   assign a_step[1] = fire && (st_q == ST_DST);

   for (genvar a = 0; a < 2; a++) begin : g_area
      dmap_area_walk #(.GROUP(GROUP), .SUM_W(SUM_W)) u_walk (
         .clk(clk), .rst_n(rst_n), .load(load), .load_cnt(a_cnt[a]),
         .load_pcie(a_pcie[a]), .step(a_step[a]), .word(in_data),
         .kind(a_kind[a]), .last_word(a_last[a]), .empty(a_empty[a]),
         .size_bad(a_zero[a]), .add(a_add[a])
      );
      dmap_byte_sum #(.SUM_W(SUM_W)) u_sum (
         .clk(clk), .rst_n(rst_n), .clear(load), .en(a_step[a]),
         .add(a_add[a]), .sum_next(a_sum[a])
      );
   end

   always_comb begin
      case (st_q)
         ST_SRC:  cur_kind = a_kind[0];
         ST_DST:  cur_kind = a_kind[1];
         default: cur_kind = WK_HDR;
      endcase
      word_bad = (a_step[0] && (a_kind[0] == WK_LOCAL) && a_zero[0]) ||
                 (a_step[1] && (a_kind[1] == WK_LOCAL) && a_zero[1]);
      case (st_q)
         ST_SRC:  done = a_step[0] && a_last[0] && a_empty[1];
         ST_DST:  done = a_step[1] && a_last[1];
         default: done = load && (h_nsrc == '0) && (h_ndst == '0);
      endcase
      err_now = (load ? h_bad : err_q) | word_bad | (a_sum[0] != a_sum[1]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         st_q    <= ST_HDR;
         err_q   <= 1'b0;
         typ_q   <= '0;
         ptr_q   <= '0;
         sw_q    <= '0;
         dw_q    <= '0;
         k_valid <= 1'b0;
         k_kind  <= WK_HDR;
         d_valid <= 1'b0;
         d_type  <= '0;
         d_first_words <= '0;
         d_last_words  <= '0;
         d_bytes <= '0;
         d_ptr   <= '0;
         d_error <= 1'b0;
      end else begin
         ready_q <= 1'b1;
         k_valid <= fire;
         k_kind  <= cur_kind;
         d_valid <= done;
         if (load) begin
            err_q <= h_bad;
            typ_q <= h_xfer;
            ptr_q <= h_ptr;
            sw_q  <= h_src_words;
            dw_q  <= h_dst_words;
         end else if (word_bad) begin
            err_q <= 1'b1;
         end
         if (done) begin
            d_type        <= load ? h_xfer : typ_q;
            d_ptr         <= load ? h_ptr : ptr_q;
            d_first_words <= load ? h_src_words : sw_q;
            d_last_words  <= load ? h_dst_words : dw_q;
            d_bytes       <= a_sum[0];
            d_error       <= err_now;
         end
         case (st_q)
            ST_HDR: if (load) begin
               if (h_nsrc != '0)      st_q <= ST_SRC;
               else if (h_ndst != '0) st_q <= ST_DST;
            end
            ST_SRC: if (a_step[0] && a_last[0]) st_q <= a_empty[1] ? ST_HDR : ST_DST;
            ST_DST: if (a_step[1] && a_last[1]) st_q <= ST_HDR;
            default: st_q <= ST_HDR;
         endcase
      end
   end

   assert_desc_after_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid |-> $past(fire));
   assert_kind_after_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      k_valid |-> $past(fire));
   assert_header_label_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HDR && fire) |=> (k_kind == WK_HDR));
   assert_budget_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid && (int'(d_first_words) + int'(d_last_words) > int'(MAX_WORDS))) |-> d_error);
   assert_zero_size_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (word_bad && !done) |=> err_q);
   assert_no_ready_no_label_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_ready) |-> !k_valid);
endmodule

// File: tb/sim_dmap_instr_parse.sv
module sim_dmap_instr_parse;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_data = '0;
   logic        in_ready, k_valid, d_valid, d_error;
   logic [1:0]  k_kind, d_type;
   logic [4:0]  d_first_words, d_last_words;
   logic [19:0] d_bytes;
   logic [39:0] d_ptr;

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;

   logic [63:0] wq [64];
   int          kinds [64];
   int          nw;
   int          vals [2][16];
   int          e_fw, e_lw, e_bytes, e_type;
   bit          e_err;
   logic [39:0] e_ptr;

   always #2 clk = ~clk;

   dmap_instr_parse u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .k_valid(k_valid), .k_kind(k_kind), .d_valid(d_valid), .d_type(d_type),
      .d_first_words(d_first_words), .d_last_words(d_last_words), .d_bytes(d_bytes),
      .d_ptr(d_ptr), .d_error(d_error)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         mismatched++;
         $display("FAIL R4 watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   task automatic check(input string req, input string what, input longint act, input longint exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] mk_hdr(input logic [3:0] rsvd, input logic [1:0] fp,
      input logic [1:0] lp, input logic [1:0] typ, input logic wqe, input logic [4:0] flags,
      input logic [3:0] ndst, input logic [3:0] nsrc, input logic [39:0] ptr);
      return {rsvd, fp, lp, typ, wqe, flags, ndst, nsrc, ptr};
   endfunction

   function automatic bit hdr_rules_broken(input logic [63:0] h);
      int typ;
      bit e;
      typ = int'(h[55:54]);
      e = (h[63:60] != 0);
      if ((typ == 1 || typ == 2) && h[52:48] != 0) e = 1;
      if (typ == 3 && h[49:48] != 0) e = 1;
      if (typ != 3 && h[59:58] != 0) e = 1;
      if (typ == 2 && h[57:56] != 0) e = 1;
      if (h[53] && h[2:0] != 0) e = 1;
      return e;
   endfunction

   task automatic build(input logic [63:0] hdr, input bit balance, input bit zero_one);
      int n [2];
      bit pc [2];
      int tot [2];
      int s, need, lim;
      bit zbad, zdone;
      logic [63:0] w;
      n[0] = int'(hdr[43:40]);
      n[1] = int'(hdr[47:44]);
      pc[0] = (hdr[55:54] == 2'd3);
      pc[1] = (hdr[55:54] != 2'd2);
      for (int a = 0; a < 2; a++)
         for (int i = 0; i < n[a]; i++) vals[a][i] = 1 + int'($urandom % 300);
      s = 0;
      for (int i = 0; i < n[0]; i++) s += vals[0][i];
      if (balance && n[1] > 0) begin
         need = s;
         for (int i = 0; i < n[1] - 1; i++) need -= vals[1][i];
         lim = pc[1] ? 65535 : 8191;
         if (need >= 1 && need <= lim) vals[1][n[1]-1] = need;
      end
      zdone = 0;
      if (zero_one)
         for (int a = 0; a < 2; a++)
            if (!zdone && !pc[a] && n[a] > 0) begin
               vals[a][$urandom % n[a]] = 0;
               zdone = 1;
            end
      zbad = 0;
      nw = 1;
      wq[0] = hdr;
      kinds[0] = 0;
      for (int a = 0; a < 2; a++) begin
         tot[a] = 0;
         for (int i = 0; i < n[a]; i++) begin
            tot[a] += vals[a][i];
            if (!pc[a] && vals[a][i] == 0) zbad = 1;
         end
         if (pc[a]) begin
            for (int p = 0; p < n[a]; p += 4) begin
               w = '0;
               for (int g = 0; g < 4; g++)
                  w[63-16*g -: 16] = (p + g < n[a]) ? 16'(vals[a][p+g]) : 16'($urandom);
               wq[nw] = w; kinds[nw] = 3; nw++;
               for (int g = 0; g < 4; g++)
                  if (p + g < n[a]) begin
                     wq[nw] = {$urandom, $urandom}; kinds[nw] = 2; nw++;
                  end
            end
         end else begin
            for (int i = 0; i < n[a]; i++) begin
               w = {$urandom, $urandom};
               w[52:40] = 13'(vals[a][i]);
               wq[nw] = w; kinds[nw] = 1; nw++;
            end
         end
      end
      e_fw = pc[0] ? n[0] + (n[0] + 3) / 4 : n[0];
      e_lw = pc[1] ? n[1] + (n[1] + 3) / 4 : n[1];
      e_bytes = tot[0];
      e_type = int'(hdr[55:54]);
      e_ptr = hdr[39:0];
      e_err = hdr_rules_broken(hdr) || zbad || (tot[0] != tot[1]) || (e_fw + e_lw > 31);
   endtask

   task automatic send_instr(input string tag);
      @(negedge clk);
      check("R4", "no descriptor between instructions", longint'(d_valid), 0);
      for (int i = 0; i < nw; i++) begin
         if (i > 0) begin
            @(negedge clk);
            check("R3", "label valid", longint'(k_valid), 1);
            check("R3", "word label", longint'(k_kind), longint'(kinds[i-1]));
            check("R4", "descriptor early", longint'(d_valid), 0);
            if ($urandom % 6 == 0) begin
               in_valid = 1'b0;
               @(negedge clk);
               check("R3", "no label on idle", longint'(k_valid), 0);
            end
         end
         in_valid = 1'b1;
         in_data = wq[i];
      end
      @(negedge clk);
      in_valid = 1'b0;
      check("R3", "final word label", longint'(k_kind), longint'(kinds[nw-1]));
      check("R4", "descriptor pulse", longint'(d_valid), 1);
      check(tag, "error flag", longint'(d_error), longint'(e_err));
      check("R1", "direction", longint'(d_type), longint'(e_type));
      check("R1", "pointer", longint'(d_ptr), longint'(e_ptr));
      check("R2", "source words", longint'(d_first_words), longint'(e_fw));
      check("R2", "destination words", longint'(d_last_words), longint'(e_lw));
      check("R7", "source bytes", longint'(d_bytes), longint'(e_bytes));
   endtask

   function automatic logic [63:0] rand_hdr();
      int typ;
      logic [4:0] fl;
      logic [1:0] fp, lp;
      logic [39:0] ptr;
      logic wqe;
      int ns, nd;
      logic [63:0] h;
      typ = int'($urandom % 4);
      fl = 5'($urandom);
      if (typ == 1 || typ == 2) fl = '0;
      if (typ == 3) fl = fl & 5'b11100;
      fp = (typ == 3) ? 2'($urandom) : 2'b00;
      lp = (typ == 2) ? 2'b00 : 2'($urandom);
      wqe = 1'($urandom);
      ptr = {8'($urandom), 32'($urandom)};
      if (wqe) ptr[2:0] = 3'b000;
      ns = int'($urandom % 9);
      nd = int'($urandom % 9);
      if ($urandom % 8 == 0) begin ns = 10 + int'($urandom % 6); nd = 10 + int'($urandom % 6); end
      h = mk_hdr(4'b0, fp, lp, 2'(typ), wqe, fl, 4'(nd), 4'(ns), ptr);
      if ($urandom % 5 == 0) h[48 + ($urandom % 16)] ^= 1'b1;
      return h;
   endfunction

   initial begin
      void'($urandom(32'd4471));
      repeat (3) @(negedge clk);
      check("R13", "ready low in reset", longint'(in_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R13", "ready after reset", longint'(in_ready), 1);
      check("R13", "no label after reset", longint'(k_valid), 0);
      check("R13", "no descriptor after reset", longint'(d_valid), 0);

      // header-only instruction
      build(mk_hdr(0, 0, 1, 2'd0, 0, 5'b10101, 0, 0, 40'h12_3456_789A), 1, 0);
      send_instr("R4");

      // back-to-back header-only instructions
      @(negedge clk);
      in_valid = 1'b1;
      in_data = mk_hdr(0, 0, 0, 2'd1, 0, 0, 0, 0, 40'h1);
      @(negedge clk);
      check("R4", "first back-to-back pulse", longint'(d_valid), 1);
      in_data = mk_hdr(0, 2, 0, 2'd3, 1, 0, 0, 0, 40'h8);
      @(negedge clk);
      in_valid = 1'b0;
      check("R4", "second back-to-back pulse", longint'(d_valid), 1);
      check("R4", "second back-to-back direction", longint'(d_type), 3);
      check("R11", "aligned work-entry pointer", longint'(d_error), 0);

      build(mk_hdr(0, 0, 0, 2'd2, 0, 0, 3, 2, 40'h40), 1, 0);
      send_instr("R2");
      build(mk_hdr(0, 0, 2, 2'd0, 0, 5'b11111, 1, 1, 40'h0), 1, 0);
      send_instr("R7");
      build(mk_hdr(0, 1, 3, 2'd3, 0, 5'b11100, 6, 5, 40'h77), 1, 0);
      send_instr("R2");
      build(mk_hdr(0, 0, 0, 2'd2, 0, 0, 2, 3, 40'h5), 1, 1);
      send_instr("R6");
      build(mk_hdr(0, 0, 0, 2'd3, 0, 0, 15, 15, 40'h6), 1, 0);
      send_instr("R5");
      build(mk_hdr(0, 0, 0, 2'd1, 0, 0, 2, 2, 40'h9), 1, 0);
      send_instr("R12");
      build(mk_hdr(4'h2, 0, 0, 2'd0, 0, 0, 1, 1, 40'h0), 1, 0);
      send_instr("R10");
      build(mk_hdr(0, 0, 0, 2'd1, 0, 5'b01000, 1, 1, 40'h0), 1, 0);
      send_instr("R8");
      build(mk_hdr(0, 0, 0, 2'd3, 0, 5'b00001, 1, 1, 40'h0), 1, 0);
      send_instr("R8");
      build(mk_hdr(0, 1, 0, 2'd0, 0, 0, 1, 1, 40'h0), 1, 0);
      send_instr("R9");
      build(mk_hdr(0, 0, 1, 2'd2, 0, 0, 1, 1, 40'h0), 1, 0);
      send_instr("R9");
      build(mk_hdr(0, 0, 0, 2'd0, 1, 0, 1, 1, 40'h13), 1, 0);
      send_instr("R11");
      build(mk_hdr(0, 0, 0, 2'd0, 0, 0, 3, 2, 40'h0), 0, 0);
      vals[1][0] = vals[1][0];
      send_instr("R7");

      for (int k = 0; k < 200; k++) begin
         build(rand_hdr(), ($urandom % 8) != 0, ($urandom % 10) == 0);
         send_instr("R12");
      end

      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule